// File: doc/BRIEF.md
# Register-Mapped PWM Timer

This block is a single-channel pulse-width modulation timer that sits on a simple 32-bit register bus. Software programs three registers. The first holds the duty count and the second holds the period count. The third is a control word that starts and stops the timer, sets the output polarity and the single-pulse mode, manages the period-end interrupt and drives the pad output-enable. A counter driven by the peripheral clock runs from zero to one less than the period and then wraps. The output carries the active level while the count is below the duty count.

A two-state machine owns the running condition. Its states are ST_IDLE and ST_RUN. The START transition goes from ST_IDLE to ST_RUN on a control write with bit 0 set. The STOP transition goes from ST_RUN to ST_IDLE on a control write with bit 0 clear. The ONESHOT_END transition goes from ST_RUN to ST_IDLE on a counter wrap while single-pulse mode is set and no control write occurs in that cycle. A control write in ST_RUN with bit 0 set keeps the state in ST_RUN. The control register reads back the state in bit 0. Converting times to clock counts is left to software.

Top module: `pulse_timer`

## Requirements
- R1: The duty register is at byte offset 0x4, the period register at 0x8 and the control register at 0xC. Each register reads back what was written. The control layout is: bit0 run, bit3 output-disable (active high), bit4 single pulse, bit5 interrupt enable, bit6 wrap flag, bit7 counter clear, bit8 capture enable, bit9 invert, bit10 dead-zone enable. All other control bits read 0, and any unmapped offset reads 0.
- R2: While running, the counter steps by one each clock and returns to 0 in the clock after it reaches period-1. A period of 0 or 1 wraps on every clock. The first running cycle after START has a count of 0.
- R3: While running, the output is high when the count is below duty and low otherwise. Setting invert (bit9) swaps the two levels. A duty at or above the period gives a constant active level.
- R4: When duty and period are both 0, the output is low whatever the invert setting.
- R5: In ST_IDLE the output is 0 whatever the polarity. A STOP write drives the output to 0 in the next cycle, and the counter returns to 0.
- R6: A new duty or period value is used for the comparison from the cycle right after the write, and the current period is not completed with the old values.
- R7: Every wrap sets the flag (bit6). Writing 1 to bit6 clears the flag, but a wrap in the same cycle wins. The irq output equals the flag AND the interrupt enable (bit5).
- R8: With single pulse (bit4) set, the first wrap takes ONESHOT_END, and bit0 then reads 0. A control write in that same cycle takes precedence.
- R9: A control write with bit7 set zeroes the counter. Bit7 always reads back 0.
- R10: The pwm_oe output is the inverse of control bit3.
- R11: The capture enable (bit8) and dead-zone enable (bit10) are stored and read back, but have no effect on any output.
- R12: A synchronous active-low reset clears all registers, the flag and the counter, and leaves the state in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pwm_out | output | 1 | PWM waveform |
| pwm_oe | output | 1 | Pad output-enable, high when driving |
| irq | output | 1 | Interrupt, flag AND enable |

## Verification
If the run state is wrong, pwm_out and control bit 0 disagree with the expected waveform in the very next sampled cycle, because the state directly gates the output. An off-by-one counter or a wrong wrap point first appears as a shifted edge on pwm_out, and then at the next wrap as a wrap flag that is early or late. A bad flag update is seen on irq and in control bit 6 one cycle after the causing edge. A cycle-accurate model in the bench, compared on every cycle over a long random mix of register writes, catches each of these faults within a period or two.

// File: rtl/pt_pkg.sv
package pt_pkg;

    // register byte offsets
    localparam int OFS_DUTY = 4;
    localparam int OFS_PER  = 8;
    localparam int OFS_CTL  = 12;

    // control bit positions
    localparam int B_RUN  = 0;
    localparam int B_OEN  = 3;
    localparam int B_ONE  = 4;
    localparam int B_IE   = 5;
    localparam int B_FLAG = 6;
    localparam int B_CLR  = 7;
    localparam int B_CAP  = 8;
    localparam int B_INV  = 9;
    localparam int B_DZ   = 10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

endpackage

// File: rtl/pt_core.sv
module pt_core
    import pt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_run_wd,
    input  logic             ctl_clr_wd,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] period,
    input  logic             inv,
    input  logic             single,
    output logic             running,
    output logic             wrap,
    output logic             pwm_level
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    run_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    assign running = (state_q == ST_RUN);
    assign wrap    = running && ((period == '0) || (cnt_q >= period - ONE));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctl_wr && ctl_run_wd) state_d = ST_RUN;          // START
            ST_RUN: begin
                if (ctl_wr)               state_d = ctl_run_wd ? ST_RUN : ST_IDLE; // STOP
                else if (wrap && single)  state_d = ST_IDLE;              // ONESHOT_END
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter
    always_ff @(posedge clk) begin
        if (!rst_n)                                       cnt_q <= '0;
        else if (state_q != ST_RUN || state_d != ST_RUN)  cnt_q <= '0;
        else if (ctl_wr && ctl_clr_wd)                    cnt_q <= '0;
        else if (wrap)                                    cnt_q <= '0;
        else                                              cnt_q <= cnt_q + ONE;
    end

    // output logic
    always_comb begin
        pwm_level = 1'b0;
        unique case (state_q)
            ST_IDLE: pwm_level = 1'b0;
            ST_RUN: begin
                if (duty == '0 && period == '0) pwm_level = 1'b0;
                else                            pwm_level = (cnt_q < duty) ^ inv;
            end
        endcase
    end

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_clr_wd) |=> (cnt_q == '0));

    // R5
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_run_wd) |=> (!pwm_level && !running));

    // R8
    oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wrap && single && !ctl_wr) |=> !running);

endmodule

// File: rtl/pt_regs.sv
module pt_regs
    import pt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              running,
    input  logic              wrap,
    output logic              ctl_wr,
    output logic [DATA_W-1:0] duty,
    output logic [DATA_W-1:0] period,
    output logic              inv,
    output logic              single,
    output logic              irq,
    output logic              oe,
    output logic [DATA_W-1:0] bus_rdata
);

    logic oen_q, ie_q, flag_q, cap_q, dz_q;
    logic [DATA_W-1:0] ctl_rd;

    assign ctl_wr = bus_we && (bus_addr == ADDR_W'(OFS_CTL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty   <= '0;
            period <= '0;
            oen_q  <= 1'b0;
            single <= 1'b0;
            ie_q   <= 1'b0;
            cap_q  <= 1'b0;
            inv    <= 1'b0;
            dz_q   <= 1'b0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(OFS_DUTY)) duty   <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_PER))  period <= bus_wdata;
            if (ctl_wr) begin
                oen_q  <= bus_wdata[B_OEN];
                single <= bus_wdata[B_ONE];
                ie_q   <= bus_wdata[B_IE];
                cap_q  <= bus_wdata[B_CAP];
                inv    <= bus_wdata[B_INV];
                dz_q   <= bus_wdata[B_DZ];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           flag_q <= 1'b0;
        else if (wrap)                        flag_q <= 1'b1;
        else if (ctl_wr && bus_wdata[B_FLAG]) flag_q <= 1'b0;
    end

    assign irq = flag_q && ie_q;
    assign oe  = !oen_q;

    always_comb begin
        ctl_rd         = '0;
        ctl_rd[B_RUN]  = running;
        ctl_rd[B_OEN]  = oen_q;
        ctl_rd[B_ONE]  = single;
        ctl_rd[B_IE]   = ie_q;
        ctl_rd[B_FLAG] = flag_q;
        ctl_rd[B_CAP]  = cap_q;
        ctl_rd[B_INV]  = inv;
        ctl_rd[B_DZ]   = dz_q;
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_DUTY): bus_rdata = duty;
            ADDR_W'(OFS_PER):  bus_rdata = period;
            ADDR_W'(OFS_CTL):  bus_rdata = ctl_rd;
            default:           bus_rdata = '0;
        endcase
    end

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (flag_q && (irq == ie_q)));

    // R1
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CTL)) |-> !bus_rdata[B_CLR]);

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
    import pt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out,
    output logic              pwm_oe,
    output logic              irq
);

    logic              ctl_wr, running, wrap, inv, single;
    logic [DATA_W-1:0] duty, period;

    pt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .running   (running),
        .wrap      (wrap),
        .ctl_wr    (ctl_wr),
        .duty      (duty),
        .period    (period),
        .inv       (inv),
        .single    (single),
        .irq       (irq),
        .oe        (pwm_oe),
        .bus_rdata (bus_rdata)
    );

    pt_core #(.CNT_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_run_wd (bus_wdata[B_RUN]),
        .ctl_clr_wd (bus_wdata[B_CLR]),
        .duty       (duty),
        .period     (period),
        .inv        (inv),
        .single     (single),
        .running    (running),
        .wrap       (wrap),
        .pwm_level  (pwm_out)
    );

    // R4
    zero_cfg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0 && period == '0) |-> !pwm_out);

    // R10
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_CTL)) |=> (pwm_oe == !$past(bus_wdata[B_OEN])));

endmodule

// File: tb/sim_pulse_timer.sv
module sim_pulse_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out, pwm_oe, irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pulse_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq)
    );

    // behavioural model built from the requirements
    logic [31:0] m_duty, m_per, m_cnt;
    bit m_run, m_flag, m_oen, m_one, m_ie, m_cap, m_inv, m_dz;

    always @(posedge clk) begin
        bit wr_c, wrp, run_n;
        if (!rst_n) begin
            m_duty = 0; m_per = 0; m_cnt = 0; m_run = 0; m_flag = 0;
            m_oen = 0; m_one = 0; m_ie = 0; m_cap = 0; m_inv = 0; m_dz = 0;
        end else begin
            wr_c  = bus_we && bus_addr == 4'hC;
            wrp   = m_run && (m_per == 0 || m_cnt >= m_per - 1);
            run_n = m_run;
            if (wr_c) run_n = bus_wdata[0];
            else if (wrp && m_one) run_n = 0;
            if (!run_n || !m_run)           m_cnt = 0;
            else if (wr_c && bus_wdata[7])  m_cnt = 0;
            else if (wrp)                   m_cnt = 0;
            else                            m_cnt = m_cnt + 1;
            if (wrp) m_flag = 1;
            else if (wr_c && bus_wdata[6]) m_flag = 0;
            if (bus_we && bus_addr == 4'h4) m_duty = bus_wdata;
            if (bus_we && bus_addr == 4'h8) m_per = bus_wdata;
            if (wr_c) begin
                m_oen = bus_wdata[3]; m_one = bus_wdata[4]; m_ie = bus_wdata[5];
                m_cap = bus_wdata[8]; m_inv = bus_wdata[9]; m_dz = bus_wdata[10];
            end
            m_run = run_n;
        end
    end

    function automatic logic exp_out();
        if (!m_run) return 1'b0;
        if (m_duty == 0 && m_per == 0) return 1'b0;
        return (m_cnt < m_duty) ^ m_inv;
    endfunction

    function automatic logic [31:0] exp_rd(logic [3:0] a);
        logic [31:0] c;
        c = '0;
        c[0] = m_run; c[3] = m_oen; c[4] = m_one; c[5] = m_ie; c[6] = m_flag;
        c[8] = m_cap; c[9] = m_inv; c[10] = m_dz;
        case (a)
            4'h4: return m_duty;
            4'h8: return m_per;
            4'hC: return c;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "pwm_out", 32'(pwm_out), 32'(exp_out()));
        chk(tag, "irq", 32'(irq), 32'(m_flag && m_ie));
        chk(tag, "pwm_oe", 32'(pwm_oe), 32'(!m_oen));
        chk(tag, "rdata", bus_rdata, exp_rd(bus_addr));
    endtask

    task automatic cyc(string tag);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, string tag);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc(tag);
        bus_we = 1'b0; bus_addr = 4'hC;
    endtask

    task automatic rd(logic [3:0] a, string tag);
        bus_addr = a;
        cyc(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R12: reset state
        run(3, "R12");
        rst_n = 1'b1;
        rd(4'h4, "R12"); rd(4'h8, "R12"); rd(4'hC, "R12");

        // R1: readback and map
        wr(4'h4, 32'h1234_5678, "R1");
        wr(4'h8, 32'h8765_4321, "R1");
        wr(4'hC, 32'h0000_07F8, "R1");
        rd(4'h4, "R1"); rd(4'h8, "R1"); rd(4'hC, "R1"); rd(4'h0, "R1");
        chk("R1", "ctrl bit7", 32'(bus_rdata[7]), 32'h0);
        wr(4'hC, 32'h0, "R1");

        // R4: zero configuration with invert
        wr(4'h4, 0, "R4"); wr(4'h8, 0, "R4");
        wr(4'hC, 32'h201, "R4"); run(6, "R4");
        chk("R4", "pwm_out zero cfg", 32'(pwm_out), 32'h0);
        wr(4'hC, 32'h001, "R4"); run(4, "R4");

        // R3: normal, inverted, saturated duty
        wr(4'hC, 0, "R3");
        wr(4'h4, 2, "R3"); wr(4'h8, 5, "R3");
        wr(4'hC, 32'h1, "R3"); run(12, "R3");
        wr(4'hC, 32'h201, "R3"); run(10, "R3");
        wr(4'h4, 7, "R3"); run(8, "R3");

        // R11: capture and dead-zone bits inert
        wr(4'h4, 3, "R11"); wr(4'hC, 32'h501, "R11"); run(10, "R11");

        // R6: mid-period updates
        wr(4'h8, 9, "R6"); run(3, "R6");
        wr(4'h8, 3, "R6"); run(2, "R6");
        wr(4'h4, 1, "R6"); run(6, "R6");

        // R2: short periods
        wr(4'h8, 1, "R2"); run(4, "R2");
        wr(4'h8, 0, "R2"); run(4, "R2");
        wr(4'h8, 4, "R2"); run(9, "R2");

        // R7: interrupt flag
        wr(4'hC, 32'h21, "R7"); run(6, "R7");
        wr(4'hC, 32'h61, "R7"); run(6, "R7");
        wr(4'h8, 0, "R7"); wr(4'hC, 32'h61, "R7");
        chk("R7", "irq set wins", 32'(irq), 32'h1);

        // R9: counter clear
        wr(4'h4, 3, "R9"); wr(4'h8, 8, "R9"); run(5, "R9");
        wr(4'hC, 32'h81, "R9"); run(6, "R9");
        chk("R9", "ctrl bit7", 32'(bus_rdata[7]), 32'h0);

        // R5: stop at once
        wr(4'hC, 32'h201, "R5"); run(2, "R5");
        wr(4'hC, 32'h200, "R5");
        chk("R5", "pwm_out after stop", 32'(pwm_out), 32'h0);
        run(4, "R5");

        // R10: output-enable
        wr(4'hC, 32'h8, "R10");
        chk("R10", "pwm_oe", 32'(pwm_oe), 32'h0);
        wr(4'hC, 32'h0, "R10");
        chk("R10", "pwm_oe", 32'(pwm_oe), 32'h1);

        // R8: single pulse
        wr(4'h4, 2, "R8"); wr(4'h8, 3, "R8");
        wr(4'hC, 32'h11, "R8"); run(6, "R8");
        chk("R8", "run bit after pulse", 32'(bus_rdata[0]), 32'h0);

        // random mix, checked against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [31:0] w;
            r = $urandom % 10;
            if (r < 2) wr(4'h4, $urandom % 7, "R3");
            else if (r == 2) wr(4'h8, $urandom % 8, "R2");
            else if (r == 3) begin
                w = $urandom & 32'h77F;
                w[0] = ($urandom % 4) != 0;
                w[7] = ($urandom % 8) == 0;
                wr(4'hC, w, "R7");
            end else begin
                bus_addr = 4'(($urandom % 4) * 4);
                cyc("R1");
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule